// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block is a half-duplex synchronous serial port for a microcontroller-style peripheral. It moves 8-bit frames over one bidirectional data line and drives the shift clock for that line itself. The shift clock is the system clock divided by a fixed factor of 12. No baud divider can be set. Each frame is 96 system clocks long, and the least significant bit goes first.

Software starts a transmit frame by handing a byte to the write stream. The write stream is a valid/ready pair. `wr_ready` is high only while no frame is running, and a byte is taken on a clock edge where both `wr_valid` and `wr_ready` are high. The port does not apply back-pressure by holding a byte: a byte offered while `wr_ready` is low is dropped, and the current frame runs on unchanged.

Software starts a receive frame by pulsing `clr_rx` while the port is idle and `rx_enable` is high. When a receive frame ends, the captured byte appears on `rd_data` on the same edge that raises `rx_done`. The data line is driven only during a transmit frame. At all other times the port releases it.

Top module: `sync_shift_port`

## Requirements
- R1: During and right after reset, the outputs are in the idle state: `sclk`=1, `sd_oe`=0, `sd_out`=1, `wr_ready`=1, `tx_done`=0, `rx_done`=0 and `rd_data`=0.
- R2: A write taken at clock edge k (`wr_valid`=1 and `wr_ready`=1) starts a transmit frame. From edge k on, `sd_oe` is 1 and `wr_ready` is 0 for exactly 96 clocks. Both return to their idle values at edge k+96.
- R3: `sclk` is 1 whenever no frame is running. During a frame, each bit period is 12 clocks long: `sclk` is 0 for the first 10 clocks and 1 for the last 2. Bit periods follow one another with no gap.
- R4: During a transmit frame, `sd_out` carries bit n of the written byte for all 12 clocks of bit period n, for n from 0 to 7. The byte is therefore sent LSB first, and each bit is valid 10 clocks before the rising edge of `sclk` and for 2 clocks after it. `sd_out` is 1 when the port is not transmitting.
- R5: `tx_done` goes to 1 on the edge that ends the eighth transmit bit period. It stays at 1 until `clr_tx` is pulsed. If the set and the clear fall on the same edge, the set wins.
- R6: A `clr_rx` pulse while the port is idle, with `rx_enable`=1 and no write taken on that edge, starts a receive frame. During a receive frame, `sd_oe` stays 0 and `wr_ready` stays 0.
- R7: In a receive frame, `sd_in` is sampled on the system clock edge on which `sclk` rises, which is the 10th edge of each bit period. The first sample becomes bit 0 of the byte.
- R8: On the edge that ends the eighth receive bit period, `rd_data` takes the received byte and `rx_done` goes to 1, on the same edge.
- R9: While a frame is running, a byte offered on the write stream is dropped and a `clr_rx` pulse has no effect. The running frame carries on unchanged and `rx_done` keeps its value.
- R10: A `clr_rx` pulse while the port is idle always clears `rx_done`. With `rx_enable`=0 it starts no frame. If a write is taken on the same edge, the transmit frame starts and no receive frame does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | A byte to transmit is offered |
| wr_ready | output | 1 | High when the port is idle and can take a byte |
| wr_data | input | 8 | Byte to transmit |
| rx_enable | input | 1 | Allows `clr_rx` to start a receive frame |
| clr_rx | input | 1 | Pulse: clear the receive-done flag and, when allowed, start a receive frame |
| clr_tx | input | 1 | Pulse: clear the transmit-done flag |
| rd_data | output | 8 | Last byte received |
| tx_done | output | 1 | Transmit-done flag |
| rx_done | output | 1 | Receive-done flag |
| sclk | output | 1 | Shift clock |
| sd_out | output | 1 | Serial data driven onto the line |
| sd_oe | output | 1 | Output enable for the serial data line |
| sd_in | input | 1 | Serial data read from the line |

## Verification
The bench keeps a behavioural model of the port, tracking position within the frame, the byte and the flags, and compares it with every port on every clock. It sends a new pseudo-random value on `sd_in` every clock. A design that samples one clock early or late therefore ends up with a different byte, and a design whose bit period or low/high split is off by one clock shows a mismatch in `sclk` or `sd_out`.

Writes and `clr_rx` pulses are sent in the middle of a frame. A design that restarts or reloads the frame then sends the wrong byte, drops `wr_ready` out of step, or clears `rx_done`. The bench also tests:
- a write taken on the very edge where `wr_ready` returns high;
- a write and a receive start offered on the same edge;
- a `clr_rx` pulse with receive disabled.

// File: rtl/sps_pkg.sv
package sps_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_TX   = 2'd1,
    MODE_RX   = 2'd2
  } sps_mode_e;
endpackage

// File: rtl/sps_timer.sv
// Bit-period timer: phase within a bit, index of the bit within the frame.
module sps_timer #(
  parameter int DIV   = 12,
  parameter int HIGH  = 2,
  parameter int NBITS = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     run,
  output logic [$clog2(DIV)-1:0]   phase,
  output logic                     sample_tick,
  output logic                     bit_end,
  output logic                     frame_end,
  output logic                     sclk_high
);
  localparam int PW = $clog2(DIV);
  localparam int BW = (NBITS > 1) ? $clog2(NBITS) : 1;
  localparam logic [PW-1:0] PH_LAST = PW'(DIV - 1);
  localparam logic [PW-1:0] PH_RISE = PW'(DIV - HIGH);
  localparam logic [PW-1:0] PH_SAMP = PW'(DIV - HIGH - 1);
  localparam logic [BW-1:0] BIT_LAST = BW'(NBITS - 1);

  logic [BW-1:0] bit_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= '0;
      bit_idx <= '0;
    end else if (start) begin
      phase   <= '0;
      bit_idx <= '0;
    end else if (run) begin
      if (phase == PH_LAST) begin
        phase   <= '0;
        bit_idx <= (bit_idx == BIT_LAST) ? '0 : bit_idx + 1'b1;
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  assign bit_end     = run && (phase == PH_LAST);
  assign frame_end   = bit_end && (bit_idx == BIT_LAST);
  assign sample_tick = run && (phase == PH_SAMP);
  assign sclk_high   = (phase >= PH_RISE);

  // R3
  bit_idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !bit_end && !start) |=> (bit_idx == $past(bit_idx)));
endmodule

// File: rtl/sps_shifter.sv
// Shift register shared by transmit (shift out at bit end) and receive (shift in at sample).
module sps_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         shift_in,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     q <= '0;
    else if (load)  q <= load_val;
    else if (shift) q <= {shift_in, q[W-1:1]};
  end
endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port
  import sps_pkg::*;
#(
  parameter int DIV    = 12,
  parameter int HIGH   = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rx_enable,
  input  logic              clr_rx,
  input  logic              clr_tx,
  output logic [DATA_W-1:0] rd_data,
  output logic              tx_done,
  output logic              rx_done,
  output logic              sclk,
  output logic              sd_out,
  output logic              sd_oe,
  input  logic              sd_in
);
  localparam int PW = $clog2(DIV);

  sps_mode_e         mode;
  logic              idle, accept_wr, start_rx, start;
  logic              sample_tick, bit_end, frame_end, sclk_high;
  logic [PW-1:0]     phase;
  logic [DATA_W-1:0] shreg;
  logic              shift, shift_in;

  assign idle      = (mode == MODE_IDLE);
  assign accept_wr = wr_valid && idle;
  assign start_rx  = clr_rx && rx_enable && idle && !wr_valid;
  assign start     = accept_wr || start_rx;

  sps_timer #(.DIV(DIV), .HIGH(HIGH), .NBITS(DATA_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .run(!idle),
    .phase(phase), .sample_tick(sample_tick), .bit_end(bit_end),
    .frame_end(frame_end), .sclk_high(sclk_high)
  );

  assign shift    = ((mode == MODE_TX) && bit_end) || ((mode == MODE_RX) && sample_tick);
  assign shift_in = (mode == MODE_RX) ? sd_in : 1'b0;

  sps_shifter #(.W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(accept_wr), .load_val(wr_data),
    .shift(shift), .shift_in(shift_in), .q(shreg)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode    <= MODE_IDLE;
      tx_done <= 1'b0;
      rx_done <= 1'b0;
      rd_data <= '0;
    end else begin
      if (accept_wr)      mode <= MODE_TX;
      else if (start_rx)  mode <= MODE_RX;
      else if (frame_end) mode <= MODE_IDLE;

      if (frame_end && mode == MODE_TX) tx_done <= 1'b1;
      else if (clr_tx)                  tx_done <= 1'b0;

      if (frame_end && mode == MODE_RX) begin
        rx_done <= 1'b1;
        rd_data <= shreg;
      end else if (clr_rx && idle) begin
        rx_done <= 1'b0;
      end
    end
  end

  assign wr_ready = idle;
  assign sd_oe    = (mode == MODE_TX);
  assign sd_out   = (mode == MODE_TX) ? shreg[0] : 1'b1;
  assign sclk     = idle || sclk_high;

  // R4
  tx_bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_TX && $past(mode) == MODE_TX && phase != '0) |-> $stable(sd_out));
  // R5
  tx_done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_done) |-> ($past(mode) == MODE_TX));
  // R8
  rd_data_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_data) |-> $rose(rx_done));
  // R9
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && !frame_end) |=> (mode == $past(mode)));
endmodule

// File: tb/tb_sync_shift_port.sv
`timescale 1ns/1ps
module tb_sync_shift_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0, rx_enable = 1'b0, clr_rx = 1'b0, clr_tx = 1'b0, sd_in = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic wr_ready, tx_done, rx_done, sclk, sd_out, sd_oe;
  logic [7:0] rd_data;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  sync_shift_port dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rx_enable(rx_enable), .clr_rx(clr_rx), .clr_tx(clr_tx), .rd_data(rd_data),
    .tx_done(tx_done), .rx_done(rx_done), .sclk(sclk), .sd_out(sd_out), .sd_oe(sd_oe),
    .sd_in(sd_in)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // new line value every clock
  logic [15:0] lfsr = 16'hACE1;
  always @(negedge clk) begin
    lfsr  <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    sd_in <= lfsr[0];
  end

  // behavioural reference model
  bit m_busy, m_tx, m_txd, m_rxd;
  int m_cnt;
  logic [7:0] m_byte, m_acc, m_rd;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_tx = 0; m_txd = 0; m_rxd = 0; m_cnt = 0;
      m_byte = 0; m_acc = 0; m_rd = 0;
    end else begin
      if (clr_tx) m_txd = 0;
      if (m_busy) begin
        if (!m_tx && (m_cnt % 12) == 9) m_acc[m_cnt / 12] = sd_in;
        if (m_cnt == 95) begin
          m_busy = 0;
          if (m_tx) m_txd = 1;
          else begin m_rd = m_acc; m_rxd = 1; end
        end else m_cnt++;
      end else begin
        if (clr_rx) m_rxd = 0;
        if (wr_valid) begin
          m_busy = 1; m_tx = 1; m_byte = wr_data; m_cnt = 0;
        end else if (clr_rx && rx_enable) begin
          m_busy = 1; m_tx = 0; m_cnt = 0;
        end
      end
    end
  end

  // per-clock comparison plus edge captures
  logic prev_sclk = 1'b1;
  int cap_n = 0, rx_n = 0;
  logic [7:0] cap_byte, rx_byte;
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      check("R3 sclk", sclk, (!m_busy || (m_cnt % 12) >= 10));
      check("R4 sd_out", sd_out, (m_busy && m_tx) ? m_byte[m_cnt / 12] : 1'b1);
      check("R6 sd_oe", sd_oe, m_busy && m_tx);
      check("R2 wr_ready", wr_ready, !m_busy);
      check("R5 tx_done", tx_done, m_txd);
      check("R8 rx_done", rx_done, m_rxd);
      check("R7 rd_data", rd_data, m_rd);
      if (sclk && !prev_sclk) begin
        if (sd_oe && cap_n < 8) begin cap_byte[cap_n] = sd_out; cap_n++; end
        if (!sd_oe && !wr_ready && rx_n < 8) begin rx_byte[rx_n] = sd_in; rx_n++; end
      end
    end
    prev_sclk = sclk;
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(logic [7:0] b);
    @(negedge clk); wr_valid = 1; wr_data = b;
    @(negedge clk); wr_valid = 0;
  endtask

  task automatic pulse_clr_rx();
    @(negedge clk); clr_rx = 1;
    @(negedge clk); clr_rx = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL R2 watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1 sclk", sclk, 1); check("R1 sd_oe", sd_oe, 0); check("R1 sd_out", sd_out, 1);
    check("R1 wr_ready", wr_ready, 1); check("R1 tx_done", tx_done, 0);
    check("R1 rx_done", rx_done, 0); check("R1 rd_data", rd_data, 0);
    rst_n = 1;
    tick(2);
    check("R1 idle sclk", sclk, 1);

    // R2 R4 R5: plain transmit
    cap_n = 0;
    send(8'hA5);
    check("R2 oe after accept", sd_oe, 1);
    wait_idle();
    check("R4 captured byte A5", cap_byte, 8'hA5);
    check("R5 tx_done set", tx_done, 1);
    tick(3);
    check("R5 tx_done held", tx_done, 1);
    @(negedge clk); clr_tx = 1; @(negedge clk); clr_tx = 0;
    check("R5 tx_done cleared", tx_done, 0);

    // R6 R7 R8: receive
    rx_enable = 1; rx_n = 0;
    pulse_clr_rx();
    check("R6 rx oe low", sd_oe, 0);
    check("R6 rx busy", wr_ready, 0);
    wait_idle();
    check("R8 rx_done set", rx_done, 1);
    check("R7 rd_data matches sampled line", rd_data, rx_byte);

    // R9: write and clr_rx inside a transmit frame are ignored
    cap_n = 0;
    send(8'h3C);
    tick(30);
    send(8'hFF);
    tick(10);
    pulse_clr_rx();
    wait_idle();
    check("R9 frame not restarted", cap_byte, 8'h3C);
    check("R9 rx_done kept", rx_done, 1);

    // R10: clr_rx with receive disabled clears the flag, starts nothing
    rx_enable = 0;
    pulse_clr_rx();
    check("R10 rx_done cleared", rx_done, 0);
    tick(5);
    check("R10 no frame", wr_ready, 1);

    // R10: write and receive start on the same edge, transmit wins
    rx_enable = 1; cap_n = 0;
    @(negedge clk); wr_valid = 1; wr_data = 8'h96; clr_rx = 1;
    @(negedge clk); wr_valid = 0; clr_rx = 0;
    check("R10 tx wins oe", sd_oe, 1);
    // R2: back-to-back write on the edge ready returns
    while (!wr_ready) @(negedge clk);
    wr_valid = 1; wr_data = 8'h0F; cap_n = 0;
    @(negedge clk); wr_valid = 0;
    check("R2 back-to-back accept", sd_oe, 1);
    wait_idle();
    check("R4 back-to-back byte", cap_byte, 8'h0F);
    tick(4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule